// File: doc/BRIEF.md
# Dual-Port RAM With Per-Port Write Modes

This block is a two-port synchronous word memory. Each of the two ports has its own enable, a write-enable bit for every column of the word, an address, write data, an output reset and a registered read output. Both ports run on one shared clock. A word is `NB_COL` columns of `COL_WIDTH` bits each, so a write can update any subset of a word's columns and leave the rest untouched.

Each port picks, by parameter, what its own output shows in a cycle where it writes: the stored word from before the write (read-first), the word as the write leaves it (write-first), or its previous output value (no-change). The choice is made each cycle as one of four named output actions: `ACT_HOLD`, `ACT_RESET`, `ACT_LOAD_OLD` and `ACT_LOAD_NEW`. The action is decided by the port's mode, enable, output reset and write mask. An optional second output stage per port adds one cycle of read latency. A parameter selects the power-up contents: all zeros, or an address pattern.

Top module: `dpram_dual`

## Requirements
- R1: Writes take effect at the clock edge. With the extra stage off, the word at the presented address appears on the port output after one clock edge.
- R2: A read-first port (mode code 0) that writes returns the word stored at that address before the write.
- R3: A write-first port (mode code 1) that writes returns the merged word: new data in the columns it enables and old stored data in the columns it does not.
- R4: A no-change port (mode code 2) keeps its output unchanged in every enabled cycle in which any of its write-enable bits is set. In other enabled cycles it reads like a read-first port.
- R5: Write-enable bit i updates only bits [(i+1)*COL_WIDTH-1 : i*COL_WIDTH] of the addressed word. All other columns keep their contents.
- R6: With enable high and output reset high, the port output loads the parameter constant (`RST_VAL_A` or `RST_VAL_B`). This overrides the read and the no-change hold. A write in the same cycle still updates the memory.
- R7: With a port's enable low, that port writes nothing and its output holds its value, whatever its write enables and output reset are.
- R8: When one port writes an address that the other port reads in the same cycle, the write lands, and the reading port receives the word from before the write.
- R9: When both ports write the same column of the same address in the same cycle, the data from port B is stored in that column.
- R10: With `OUT_REG_x`=1, read data appears after two edges. The second stage loads only while the port is enabled. An enabled reset loads the constant into both stages at the same edge.
- R11: With `INIT_PATTERN`=1, every column of word i holds the low `COL_WIDTH` bits of i at power-up. With `INIT_PATTERN`=0, every word is zero.
- R12: A port's enable and output reset have no effect on the other port's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| en_a | input | 1 | Port A enable |
| rst_a | input | 1 | Port A synchronous output reset |
| we_a | input | NB_COL | Port A column write enables |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| din_a | input | NB_COL*COL_WIDTH | Port A write data |
| dout_a | output | NB_COL*COL_WIDTH | Port A registered read data |
| en_b | input | 1 | Port B enable |
| rst_b | input | 1 | Port B synchronous output reset |
| we_b | input | NB_COL | Port B column write enables |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| din_b | input | NB_COL*COL_WIDTH | Port B write data |
| dout_b | output | NB_COL*COL_WIDTH | Port B registered read data |

## Verification
The two functions that most often meet in one cycle are a write on one port and a read of the same address on the other port. An output reset that coincides with a write on the same port is the second such case. Directed phases set up both collisions on purpose: writes to an address the other port is reading, and overlapping column masks on both ports at one address. Later phases repeat them at random with a small address range, so that clashes are frequent. A behavioural model of the memory and of each port's output is stepped on every edge and compared on every clock, for two instances that together cover all three modes. It judges that the reader saw the old word, that port B won overlapping columns, and that the reset constant won over the read while the write still landed.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        MODE_READ_FIRST  = 2'd0,
        MODE_WRITE_FIRST = 2'd1,
        MODE_NO_CHANGE   = 2'd2
    } rw_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RESET,
        ACT_LOAD_OLD,
        ACT_LOAD_NEW
    } rd_act_e;

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int DEPTH        = 1024,
    parameter int COL_WIDTH    = 8,
    parameter int NB_COL       = 4,
    parameter int INIT_PATTERN = 0,
    localparam int DW          = NB_COL * COL_WIDTH,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en_a,
    input  logic [NB_COL-1:0] we_a,
    input  logic [AW-1:0]     addr_a,
    input  logic [DW-1:0]     din_a,
    input  logic              en_b,
    input  logic [NB_COL-1:0] we_b,
    input  logic [AW-1:0]     addr_b,
    input  logic [DW-1:0]     din_b,
    output logic [DW-1:0]     word_a,
    output logic [DW-1:0]     word_b
);

    logic [DW-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = (INIT_PATTERN != 0) ? {NB_COL{COL_WIDTH'(i)}} : '0;
        end
    end

    // Port B's assignment comes after port A's, so B owns a shared column.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NB_COL; c++) begin
            if (en_a && we_a[c]) begin
                mem[addr_a][c*COL_WIDTH +: COL_WIDTH] <= din_a[c*COL_WIDTH +: COL_WIDTH];
            end
            if (en_b && we_b[c]) begin
                mem[addr_b][c*COL_WIDTH +: COL_WIDTH] <= din_b[c*COL_WIDTH +: COL_WIDTH];
            end
        end
    end

    // Stored words as they stand before the coming edge.
    assign word_a = mem[addr_a];
    assign word_b = mem[addr_b];

endmodule

// File: rtl/dpram_rdpath.sv
module dpram_rdpath #(
    parameter dpram_pkg::rw_mode_e MODE = dpram_pkg::MODE_READ_FIRST,
    parameter int OUT_REG   = 0,
    parameter int COL_WIDTH = 8,
    parameter int NB_COL    = 4,
    localparam int DW       = NB_COL * COL_WIDTH,
    parameter logic [DW-1:0] RST_VAL = 'h1D
) (
    input  logic              clk,
    input  logic              en,
    input  logic              rst,
    input  logic [NB_COL-1:0] we,
    input  logic [DW-1:0]     din,
    input  logic [DW-1:0]     old_word,
    output logic [DW-1:0]     dout
);
    import dpram_pkg::*;

    logic [DW-1:0] merged;
    logic [DW-1:0] stage1_q;
    rd_act_e       act;
    logic          rst_hit_q;

    for (genvar c = 0; c < NB_COL; c++) begin : g_col
        assign merged[c*COL_WIDTH +: COL_WIDTH] =
            we[c] ? din[c*COL_WIDTH +: COL_WIDTH] : old_word[c*COL_WIDTH +: COL_WIDTH];
    end

    always_comb begin
        act = ACT_HOLD;
        if (en) begin
            if (rst) begin
                act = ACT_RESET;
            end else begin
                unique case (MODE)
                    MODE_READ_FIRST:  act = ACT_LOAD_OLD;
                    MODE_WRITE_FIRST: act = ACT_LOAD_NEW;
                    MODE_NO_CHANGE:   act = (|we) ? ACT_HOLD : ACT_LOAD_OLD;
                    default:          act = ACT_HOLD;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_HOLD:     stage1_q <= stage1_q;
            ACT_RESET:    stage1_q <= RST_VAL;
            ACT_LOAD_OLD: stage1_q <= old_word;
            ACT_LOAD_NEW: stage1_q <= merged;
        endcase
    end

    if (OUT_REG != 0) begin : g_pipe
        logic [DW-1:0] stage2_q;
        always_ff @(posedge clk) begin
            if (en) begin
                stage2_q <= rst ? RST_VAL : stage1_q;
            end
        end
        assign dout = stage2_q;

        AST_PIPE_TRAILS: assert property (@(posedge clk) disable iff (rst)
            en |=> stage2_q == $past(stage1_q)); // R10
        AST_PIPE_IDLE: assert property (@(posedge clk) disable iff (rst)
            !en |=> $stable(stage2_q)); // R7
    end else begin : g_direct
        assign dout = stage1_q;
    end

    always_ff @(posedge clk) begin
        rst_hit_q <= en && rst;
        if (rst_hit_q) begin
            AST_RST_CONST: assert (stage1_q == RST_VAL) // R6
                else $error("output reset constant not loaded");
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(stage1_q)); // R7

    if (MODE == MODE_NO_CHANGE) begin : g_nc_chk
        AST_NOCHG_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (en && (|we)) |=> $stable(stage1_q)); // R4
    end

    if (MODE == MODE_WRITE_FIRST) begin : g_wf_chk
        AST_WF_SHOWS: assert property (@(posedge clk) disable iff (rst)
            (en && (&we)) |=> stage1_q == $past(din)); // R3
    end

endmodule

// File: rtl/dpram_dual.sv
module dpram_dual #(
    parameter int DEPTH     = 1024,
    parameter int COL_WIDTH = 8,
    parameter int NB_COL    = 4,
    parameter dpram_pkg::rw_mode_e MODE_A = dpram_pkg::MODE_READ_FIRST,
    parameter dpram_pkg::rw_mode_e MODE_B = dpram_pkg::MODE_READ_FIRST,
    parameter int OUT_REG_A = 0,
    parameter int OUT_REG_B = 0,
    parameter logic [NB_COL*COL_WIDTH-1:0] RST_VAL_A = 'h1D,
    parameter logic [NB_COL*COL_WIDTH-1:0] RST_VAL_B = 'h1D,
    parameter int INIT_PATTERN = 0,
    localparam int DW = NB_COL * COL_WIDTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en_a,
    input  logic              rst_a,
    input  logic [NB_COL-1:0] we_a,
    input  logic [AW-1:0]     addr_a,
    input  logic [DW-1:0]     din_a,
    output logic [DW-1:0]     dout_a,
    input  logic              en_b,
    input  logic              rst_b,
    input  logic [NB_COL-1:0] we_b,
    input  logic [AW-1:0]     addr_b,
    input  logic [DW-1:0]     din_b,
    output logic [DW-1:0]     dout_b
);

    logic [DW-1:0] word_a;
    logic [DW-1:0] word_b;

    dpram_store #(
        .DEPTH(DEPTH), .COL_WIDTH(COL_WIDTH), .NB_COL(NB_COL), .INIT_PATTERN(INIT_PATTERN)
    ) u_store (
        .clk(clk),
        .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
        .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
        .word_a(word_a), .word_b(word_b)
    );

    dpram_rdpath #(
        .MODE(MODE_A), .OUT_REG(OUT_REG_A), .COL_WIDTH(COL_WIDTH), .NB_COL(NB_COL),
        .RST_VAL(RST_VAL_A)
    ) u_port_a (
        .clk(clk), .en(en_a), .rst(rst_a), .we(we_a), .din(din_a),
        .old_word(word_a), .dout(dout_a)
    );

    dpram_rdpath #(
        .MODE(MODE_B), .OUT_REG(OUT_REG_B), .COL_WIDTH(COL_WIDTH), .NB_COL(NB_COL),
        .RST_VAL(RST_VAL_B)
    ) u_port_b (
        .clk(clk), .en(en_b), .rst(rst_b), .we(we_b), .din(din_b),
        .old_word(word_b), .dout(dout_b)
    );

endmodule

// File: tb/dpram_dual_test.sv
`timescale 1ns/1ps
module dpram_dual_test;
    import dpram_pkg::*;

    localparam int DEPTH = 16;
    localparam int CW    = 8;
    localparam int NC    = 4;
    localparam int DW    = NC * CW;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [DW-1:0] RV_A = 32'h0000_001D;
    localparam logic [DW-1:0] RV_B = 32'hA5A5_001D;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          en_a = 0, rst_a = 0, en_b = 0, rst_b = 0;
    logic [NC-1:0] we_a = '0, we_b = '0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] din_a = '0, din_b = '0;
    logic [DW-1:0] dout_a, dout_b, ncout_a, ncout_b;

    // uut: A read-first direct, B write-first with extra stage
    dpram_dual #(
        .DEPTH(DEPTH), .COL_WIDTH(CW), .NB_COL(NC),
        .MODE_A(MODE_READ_FIRST), .MODE_B(MODE_WRITE_FIRST),
        .OUT_REG_A(0), .OUT_REG_B(1), .RST_VAL_A(RV_A), .RST_VAL_B(RV_B),
        .INIT_PATTERN(1)
    ) uut (
        .clk(clk), .en_a(en_a), .rst_a(rst_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(dout_a), .en_b(en_b), .rst_b(rst_b), .we_b(we_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    // uut_nc: A no-change direct, B read-first with extra stage
    dpram_dual #(
        .DEPTH(DEPTH), .COL_WIDTH(CW), .NB_COL(NC),
        .MODE_A(MODE_NO_CHANGE), .MODE_B(MODE_READ_FIRST),
        .OUT_REG_A(0), .OUT_REG_B(1), .RST_VAL_A(RV_A), .RST_VAL_B(RV_B),
        .INIT_PATTERN(1)
    ) uut_nc (
        .clk(clk), .en_a(en_a), .rst_a(rst_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(ncout_a), .en_b(en_b), .rst_b(rst_b), .we_b(we_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(ncout_b)
    );

    // Reference model
    logic [DW-1:0] mm [DEPTH];
    logic [DW-1:0] e1 [4];
    logic [DW-1:0] e2 [4];
    int mode_c   [4] = '{0, 1, 2, 0};
    int outreg_c [4] = '{0, 1, 0, 1};
    logic [DW-1:0] rv_c [4] = '{RV_A, RV_B, RV_A, RV_B};

    int checks = 0;
    int fails  = 0;
    bit checking = 0;
    bit done = 0;
    string cur_req = "R6";

    task automatic model_edge();
        logic [DW-1:0] oldw [2];
        logic [DW-1:0] merg [2];
        logic [DW-1:0] n1 [4];
        logic [DW-1:0] n2 [4];
        logic [NC-1:0] wv [2];
        logic [DW-1:0] dv [2];
        logic ev [2];
        logic rv [2];
        wv[0] = we_a; wv[1] = we_b; dv[0] = din_a; dv[1] = din_b;
        ev[0] = en_a; ev[1] = en_b; rv[0] = rst_a; rv[1] = rst_b;
        oldw[0] = mm[addr_a]; oldw[1] = mm[addr_b];
        for (int s = 0; s < 2; s++) begin
            merg[s] = oldw[s];
            for (int c = 0; c < NC; c++)
                if (wv[s][c]) merg[s][c*CW +: CW] = dv[s][c*CW +: CW];
        end
        for (int p = 0; p < 4; p++) begin
            int s = p % 2;
            n1[p] = e1[p];
            n2[p] = e2[p];
            if (ev[s]) begin
                if (rv[s]) n1[p] = rv_c[p];
                else if (mode_c[p] == 0) n1[p] = oldw[s];
                else if (mode_c[p] == 1) n1[p] = merg[s];
                else if (wv[s] == '0) n1[p] = oldw[s];
                if (outreg_c[p] != 0) n2[p] = rv[s] ? rv_c[p] : e1[p];
            end
        end
        for (int p = 0; p < 4; p++) begin
            e1[p] = n1[p];
            e2[p] = n2[p];
        end
        for (int c = 0; c < NC; c++)
            if (en_a && we_a[c]) mm[addr_a][c*CW +: CW] = din_a[c*CW +: CW];
        for (int c = 0; c < NC; c++)
            if (en_b && we_b[c]) mm[addr_b][c*CW +: CW] = din_b[c*CW +: CW];
    endtask

    task automatic compare();
        logic [DW-1:0] got, exp;
        for (int p = 0; p < 4; p++) begin
            got = (p == 0) ? dout_a : (p == 1) ? dout_b : (p == 2) ? ncout_a : ncout_b;
            exp = (outreg_c[p] != 0) ? e2[p] : e1[p];
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s output%0d actual %h expected %h at %0t",
                         cur_req, p, got, exp, $time);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (checking) compare();
    endtask

    task automatic set_a(input logic e, input logic r, input logic [NC-1:0] w,
                         input int ad, input logic [DW-1:0] d);
        en_a = e; rst_a = r; we_a = w; addr_a = AW'(ad); din_a = d;
    endtask

    task automatic set_b(input logic e, input logic r, input logic [NC-1:0] w,
                         input int ad, input logic [DW-1:0] d);
        en_b = e; rst_b = r; we_b = w; addr_b = AW'(ad); din_b = d;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual no completion, expected end of run");
            finish_run();
        end
    end

    initial begin
        // R11 power-up pattern in the model
        for (int i = 0; i < DEPTH; i++) mm[i] = {NC{CW'(i)}};
        for (int p = 0; p < 4; p++) begin e1[p] = '0; e2[p] = '0; end

        // R6 reset state on all outputs
        cur_req = "R6";
        set_a(1, 1, '0, 0, '0); set_b(1, 1, '0, 0, '0);
        tick();
        checking = 1;
        tick();

        // R11 and R1: read initial contents, both ports
        cur_req = "R11";
        for (int i = 0; i < DEPTH; i++) begin
            set_a(1, 0, '0, i, '0); set_b(1, 0, '0, DEPTH - 1 - i, '0);
            tick();
        end

        // R5 R1: partial column writes then read back
        cur_req = "R5";
        set_a(1, 0, 4'b0101, 3, 32'hDEAD_BEEF); set_b(1, 0, 4'b1000, 4, 32'h1122_3344);
        tick();
        set_a(1, 0, '0, 3, '0); set_b(1, 0, '0, 4, '0);
        tick(); tick();

        // R2 R3 R4: same-port write returns old, merged or held word
        cur_req = "R3";
        set_a(1, 0, 4'b1111, 5, 32'hCAFE_0001); set_b(1, 0, 4'b0010, 9, 32'h5555_AAAA);
        tick();
        cur_req = "R4";
        set_a(1, 0, 4'b0001, 5, 32'h0000_00EE); set_b(1, 0, 4'b1111, 9, 32'h0BAD_F00D);
        tick();
        cur_req = "R2";
        set_a(1, 0, '0, 5, '0); set_b(1, 0, '0, 9, '0);
        tick(); tick();

        // R8: cross-port write and read of one address
        cur_req = "R8";
        set_a(1, 0, 4'b1111, 7, 32'h7777_0707); set_b(1, 0, '0, 7, '0);
        tick();
        set_a(1, 0, '0, 8, '0); set_b(1, 0, 4'b0110, 8, 32'h8888_8888);
        tick();
        set_a(1, 0, '0, 7, '0); set_b(1, 0, '0, 8, '0);
        tick(); tick();

        // R9: both ports write same address
        cur_req = "R9";
        set_a(1, 0, 4'b1111, 10, 32'hAAAA_AAAA); set_b(1, 0, 4'b1111, 10, 32'hBBBB_BBBB);
        tick();
        set_a(1, 0, 4'b0011, 11, 32'h1111_1111); set_b(1, 0, 4'b0110, 11, 32'h2222_2222);
        tick();
        set_a(1, 0, '0, 10, '0); set_b(1, 0, '0, 11, '0);
        tick(); tick();

        // R7: disabled port ignores write and reset
        cur_req = "R7";
        set_a(0, 1, 4'b1111, 12, 32'hFFFF_FFFF); set_b(0, 1, 4'b1111, 13, 32'hEEEE_EEEE);
        tick(); tick();
        set_a(1, 0, '0, 12, '0); set_b(1, 0, '0, 13, '0);
        tick(); tick();

        // R6: reset wins over read and no-change hold; write still lands
        cur_req = "R6";
        set_a(1, 1, 4'b1111, 14, 32'h1414_1414); set_b(1, 1, 4'b1001, 15, 32'h1515_1515);
        tick();
        set_a(1, 0, '0, 14, '0); set_b(1, 0, '0, 15, '0);
        tick(); tick();

        // R12: one port's reset and enable leave the other alone
        cur_req = "R12";
        set_a(1, 1, '0, 0, '0); set_b(1, 0, '0, 6, '0);
        tick();
        set_a(1, 0, '0, 2, '0); set_b(0, 1, '0, 6, '0);
        tick(); tick();

        // R10: extra stage under toggling enable
        cur_req = "R10";
        for (int i = 0; i < 12; i++) begin
            set_a(1, 0, '0, i, '0); set_b(i % 3 != 0, 0, '0, i, '0);
            tick();
        end

        // R1: random traffic with frequent collisions
        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            set_a(($urandom_range(0, 7) != 0), ($urandom_range(0, 15) == 0),
                  NC'($urandom_range(0, 15)), $urandom_range(0, 3), DW'($urandom));
            set_b(($urandom_range(0, 7) != 0), ($urandom_range(0, 15) == 0),
                  NC'($urandom_range(0, 15)), $urandom_range(0, 3), DW'($urandom));
            tick();
        end

        finish_run();
    end

endmodule